// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a clocked, synthesizable model of a one-time-programmable byte memory. It has an address bus, an active-low chip enable, a three-level output-enable/program-supply input, a flag that marks a high voltage on address bit 9, a byte-wide program data input, and a registered byte output with a drive-enable flag. Each clock edge samples the control pins and decodes them into one of several modes: read, verify, output disable, standby, program, program inhibit, or identification.

The array is erased to all ones. A program pulse can only clear bits. A pulse starts when chip enable goes low while the supply input is at the program level. It takes effect when chip enable returns high, and it writes the address and data that were present in the last low cycle. While address bit 9 is at high voltage and the other upper address bits are zero, a read returns a fixed identification byte in place of array data. Analog levels, supply sequencing and nanosecond timing are not modelled.

The full-size part uses `ADDR_W = 16`, which gives 65,536 bytes. The default is smaller so that elaboration stays light.

Top module: `eprom_otp`

## Requirements
- R1: The array holds 2^ADDR_W bytes. During reset `dataOe` is 0, and after reset every location reads 0xFF.
- R2: If `ceN` is 0, `oeLvl` is 2'b00 and the identification condition does not hold, then one clock later `dataOe` is 1 and `dataOut` is the stored byte at `addr`. This also serves as verify after programming.
- R3: If `ceN` is 0 and `oeLvl` is 2'b01 or 2'b11, then one clock later `dataOe` is 0.
- R4: If `ceN` is 1, then one clock later `dataOe` is 0 for every `oeLvl`. While `ceN` stays 1, no byte changes, even when `oeLvl` is 2'b10 (program inhibit).
- R5: While `oeLvl` is 2'b10 (program level), `dataOe` is 0 one clock later. A cycle with `ceN` 0 at that level, followed by a cycle with `ceN` 1, commits at the second edge.
- R6: A commit stores the old byte AND the latched data, so a cleared bit never returns to 1.
- R7: A low pulse that spans several cycles commits exactly once. It uses the `addr` and `dataIn` of its last low cycle, and the `dataIn` present at the rising cycle is not used.
- R8: A pulse whose `oeLvl` leaves 2'b10 while `ceN` is still 0 writes nothing.
- R9: Suppose `a9High` is 1, every `addr` bit other than bits 0 and 9 is 0, `ceN` is 0 and `oeLvl` is 2'b00. Then one clock later `dataOut` is 0x1E when `addr[0]` is 0 and 0x0D when it is 1, with `dataOe` 1. This takes priority over array data.
- R10: With `a9High` set but any other upper `addr` bit set, a read returns array data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; erases the array |
| addr | input | ADDR_W | Byte address |
| ceN | input | 1 | Active-low chip enable / program strobe |
| oeLvl | input | 2 | Output-enable level: 00 low, 01 high, 10 program supply, 11 high |
| a9High | input | 1 | High voltage present on address bit 9 |
| dataIn | input | 8 | Program data |
| dataOut | output | 8 | Read / verify / identification byte |
| dataOe | output | 1 | Output is driven when 1, floating when 0 |

## Verification
The assertions assume that the control pins are stable across each clock edge and hold a legal 2-bit level. They also assume that the drive flag and the byte always follow the mode decoded one edge earlier. The bench changes every input only on the falling edge and keeps `oeLvl` within its four encodings. It samples the outputs one falling edge later, so each check sees exactly one decoded cycle. Program pulses are built from whole cycles, so a rising `ceN` is always visible to the sampling edge.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_PROG = 2'b10,
    LVL_ALT  = 2'b11
  } oeLevel_t;

  typedef struct packed {
    logic showArray;
    logic showId;
    logic capture;
    logic commit;
  } ctrlStrobe_t;

  localparam logic [7:0] MFR_CODE = 8'h1E;
  localparam logic [7:0] DEV_CODE = 8'h0D;

endpackage

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic [1:0]        oeLvl,
  input  logic              a9High,
  output ctrlStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] ID_FREE = ADDR_W'(1) | (ADDR_W'(1) << 9);

  oeLevel_t level;
  logic     idAddr;
  logic     readNow;
  logic     progNow;
  logic     progPrev;

  assign level   = oeLevel_t'(oeLvl);
  assign idAddr  = a9High && ((addr & ~ID_FREE) == '0);
  assign readNow = !ceN && (level == LVL_LOW);
  assign progNow = !ceN && (level == LVL_PROG);

  always_ff @(posedge clk) begin
    if (!rstN) progPrev <= 1'b0;
    else       progPrev <= progNow;
  end

  always_comb begin
    strobe.showId    = readNow && idAddr;
    strobe.showArray = readNow && !idAddr;
    strobe.capture   = progNow;
    strobe.commit    = progPrev && ceN;
  end

endmodule

// File: rtl/eprom_datapath.sv
module eprom_datapath
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [ADDR_W-1:0] pgmAddr;
  logic [DATA_W-1:0] pgmData;
  logic [DATA_W-1:0] idByte;

  assign idByte = addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (strobe.commit) begin
      cells[pgmAddr] <= cells[pgmAddr] & pgmData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pgmAddr <= '0;
      pgmData <= '1;
    end else if (strobe.capture) begin
      pgmAddr <= addr;
      pgmData <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else if (strobe.showId) begin
      dataOut <= idByte;
      dataOe  <= 1'b1;
    end else if (strobe.showArray) begin
      dataOut <= cells[addr];
      dataOe  <= 1'b1;
    end else begin
      dataOe  <= 1'b0;
    end
  end

endmodule

// File: rtl/eprom_otp.sv
module eprom_otp
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic [1:0]        oeLvl,
  input  logic              a9High,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  ctrlStrobe_t strobe;

  eprom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN),
    .oeLvl(oeLvl), .a9High(a9High), .strobe(strobe)
  );

  eprom_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .strobe(strobe), .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: rtl/eprom_otp_chk.sv
module eprom_otp_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              ceN,
  input logic [1:0]        oeLvl,
  input logic              a9High,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);
  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeLvl == 2'b00) |=> dataOe);
  // R3
  disable_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeLvl[0]) |=> !dataOe);
  // R4
  standby_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> !dataOe);
  // R5
  program_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oeLvl == 2'b10) |=> !dataOe);
  // R9
  mfr_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeLvl == 2'b00 && a9High && addr == '0) |=> (dataOut == DATA_W'(8'h1E)));
  // R9
  dev_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeLvl == 2'b00 && a9High && addr == ADDR_W'(1)) |=> (dataOut == DATA_W'(8'h0D)));
endmodule

bind eprom_otp eprom_otp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeLvl(oeLvl),
  .a9High(a9High), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/eprom_otp_bench.sv
module eprom_otp_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] LOW = 2'b00, HIGH = 2'b01, PROG = 2'b10, ALT = 2'b11;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic          ceN;
  logic [1:0]    oeLvl;
  logic          a9High;
  logic [7:0]    dataIn;
  logic [7:0]    dataOut;
  logic          dataOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  eprom_otp #(.ADDR_W(AW), .DATA_W(8)) u_eprom_otp (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeLvl(oeLvl),
    .a9High(a9High), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [7:0] patA(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] patB(int a);
    return 8'(((a & 255) ^ 8'h5A ^ (a >> 8)) & 255);
  endfunction

  task automatic cyc(input logic [AW-1:0] a, input logic c, input logic [1:0] lv,
                     input logic hv, input logic [7:0] d);
    addr = a; ceN = c; oeLvl = lv; a9High = hv; dataIn = d;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic oeExp, input logic [7:0] dExp,
                     input logic careData);
    checks++;
    if (dataOe !== oeExp || (careData && dataOut !== dExp)) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
               req, dataOe, dataOut, oeExp, dExp);
    end
  endtask

  task automatic progPulse(input int a, input logic [7:0] d);
    cyc(AW'(a), 1'b0, PROG, 1'b0, d);
    chk("R5 float during pulse", 1'b0, 8'h00, 1'b0);
    cyc(AW'(a), 1'b1, PROG, 1'b0, 8'h00);
    model[a] = model[a] & d;
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      cyc(AW'(a), 1'b0, LOW, 1'b0, 8'h00);
      chk(req, 1'b1, model[a], 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; addr = '0; ceN = 1'b1; oeLvl = LOW; a9High = 1'b0; dataIn = '0;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset float", 1'b0, 8'h00, 1'b0);
    rstN = 1'b1;

    // R1 erased array
    readAll("R1 erased read");

    // R5 R2 first programming pass, then verify
    for (int a = 0; a < DEPTH; a++) progPulse(a, patA(a));
    readAll("R2 verify pass A");

    // R6 second pass can only clear bits
    for (int a = 0; a < DEPTH; a++) progPulse(a, patB(a));
    readAll("R6 and-only pass B");

    // R6 all-ones data leaves a byte unchanged
    progPulse(5, 8'hFF);
    cyc(AW'(5), 1'b0, LOW, 1'b0, 8'h00);
    chk("R6 ones keep byte", 1'b1, model[5], 1'b1);

    // R3 output disable, both high encodings
    cyc(AW'(7), 1'b0, HIGH, 1'b0, 8'h00);
    chk("R3 disable 01", 1'b0, 8'h00, 1'b0);
    cyc(AW'(7), 1'b0, ALT, 1'b0, 8'h00);
    chk("R3 disable 11", 1'b0, 8'h00, 1'b0);

    // R4 standby at every level, including program inhibit
    for (int lv = 0; lv < 4; lv++) begin
      cyc(AW'(9), 1'b1, 2'(lv), 1'b0, 8'h00);
      chk("R4 standby float", 1'b0, 8'h00, 1'b0);
    end
    for (int k = 0; k < 4; k++) cyc(AW'(9), 1'b1, PROG, 1'b0, 8'h00);
    cyc(AW'(9), 1'b0, LOW, 1'b0, 8'h00);
    chk("R4 inhibit no write", 1'b1, model[9], 1'b1);

    // R7 long pulse: only last low cycle data counts, committed once
    cyc(AW'(40), 1'b0, PROG, 1'b0, 8'h0F);
    cyc(AW'(41), 1'b0, PROG, 1'b0, 8'hF0);
    cyc(AW'(42), 1'b0, PROG, 1'b0, 8'h3C);
    cyc(AW'(42), 1'b1, PROG, 1'b0, 8'h00);
    model[42] = model[42] & 8'h3C;
    cyc(AW'(40), 1'b0, LOW, 1'b0, 8'h00);
    chk("R7 earlier addr untouched", 1'b1, model[40], 1'b1);
    cyc(AW'(41), 1'b0, LOW, 1'b0, 8'h00);
    chk("R7 middle addr untouched", 1'b1, model[41], 1'b1);
    cyc(AW'(42), 1'b0, LOW, 1'b0, 8'h00);
    chk("R7 last cycle data", 1'b1, model[42], 1'b1);

    // R8 aborted pulse: level leaves program while ceN low
    cyc(AW'(60), 1'b0, PROG, 1'b0, 8'h00);
    cyc(AW'(60), 1'b0, LOW, 1'b0, 8'h00);
    chk("R8 abort read", 1'b1, model[60], 1'b1);
    cyc(AW'(60), 1'b1, LOW, 1'b0, 8'h00);
    cyc(AW'(60), 1'b0, LOW, 1'b0, 8'h00);
    chk("R8 abort no write", 1'b1, model[60], 1'b1);

    // R9 identification bytes, bit 9 of addr free
    cyc(AW'(0), 1'b0, LOW, 1'b1, 8'h00);
    chk("R9 maker code", 1'b1, 8'h1E, 1'b1);
    cyc(AW'(1), 1'b0, LOW, 1'b1, 8'h00);
    chk("R9 device code", 1'b1, 8'h0D, 1'b1);
    cyc(AW'(512), 1'b0, LOW, 1'b1, 8'h00);
    chk("R9 maker code a9 set", 1'b1, 8'h1E, 1'b1);
    cyc(AW'(513), 1'b0, LOW, 1'b1, 8'h00);
    chk("R9 device code a9 set", 1'b1, 8'h0D, 1'b1);
    cyc(AW'(1), 1'b0, HIGH, 1'b1, 8'h00);
    chk("R9 id disabled float", 1'b0, 8'h00, 1'b0);

    // R10 other upper bits set: normal array read
    for (int b = 1; b < AW; b++) begin
      if (b != 9) begin
        cyc(AW'(1 << b), 1'b0, LOW, 1'b1, 8'h00);
        chk("R10 array read", 1'b1, model[1 << b], 1'b1);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule